// File: doc/BRIEF.md
# Floating-Point Control and Status Register File

This block holds the single control/status word of a floating-point coprocessor and presents it to software through several windows selected by a 5-bit register number. The full window shows the whole word. Three narrow windows each show and change only part of it: the condition codes, the exception cause and sticky flags, and the enables with rounding mode and flush-to-zero. A read-only identity register and zero-reading holes complete the register space. Read data comes out sign-extended to the output width.

On the other side, an arithmetic unit hands over one exception status vector for each completed operation. For each such vector the block replaces the cause field and accumulates the sticky flags. It also decides whether the processor must take a floating-point trap, which it signals with a one-cycle request.

Top module: `fcsr_file`

## Requirements
- R1: After reset the control word is zero. Registers 25, 26, 28 and 31 read zero, and `trapReq` is low.
- R2: Register 31 reads and writes the whole word. Bits [22:18] are reserved: they always read zero and ignore writes. The field layout is rounding mode [1:0], flags [6:2], enables [11:7], cause [17:12], condition code 0 at bit 23, flush-to-zero (FS) at bit 24, and condition codes 1..7 at [31:25].
- R3: Register 25 reads the eight condition codes packed without the gap. Bit 0 is code 0 (word bit 23), bits [7:1] are codes 1..7 (word bits [31:25]), and bits [31:8] read zero.
- R4: A write to register 25 puts wrData[0] into word bit 23 and wrData[7:1] into word bits [31:25]. No other bit changes, and FS in particular is kept.
- R5: Register 26 reads the cause [17:12] and flags [6:2] at their word positions, with zero elsewhere. A write replaces only those two fields.
- R6: Register 28 reads the enables [11:7] and rounding mode [1:0] at their word positions, with FS shown at bit 2. A write sets FS from wrData[2] and replaces the enables and rounding mode. Condition codes, cause and flags are kept.
- R7: Register 0 reads the constant `IMPL_ID` and ignores writes. Any register number other than 0, 25, 26, 28 and 31 reads zero, and writes to it change nothing.
- R8: `rdData[63:32]` always repeats `rdData[31]`.
- R9: When `opValid` is sampled high, the cause field is cleared and then set from `opStatus`. Bits [INV_KINDS-1:0] are invalid-operation kinds, and any of them sets V. The next five bits, in order, set Z (divide by zero), O (overflow), U (underflow), I (inexact) and E (unimplemented). The cause bits run I=12, U=13, O=14, Z=15, V=16, E=17. The new value is visible from the following cycle.
- R10: The same update ORs the new cause bits I, U, O, Z and V into the sticky flags, at the same bit order starting at 2. E never reaches the flags. Flags only clear by a write.
- R11: `trapReq` is high for exactly the cycle after an update whose cause shares a bit with the enables (same order starting at 7), or whose cause has E set whatever the enables. Otherwise it is low.
- R12: When a write and an update fall in the same cycle, the write merges first and the update is applied on top of the result. The trap decision uses the enables just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regNum | input | 5 | Register number for read and write |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write data |
| rdData | output | OUT_W | Combinational read data, sign-extended |
| opValid | input | 1 | Operation status present this cycle |
| opStatus | input | INV_KINDS+5 | Exception status of the operation |
| trapReq | output | 1 | One-cycle floating-point trap request |

## Verification
The hardest case to reach is a cycle where a software write and an arithmetic update land together. Here the trap decision must use enables that have not yet been stored, and the flags must merge the written value with the new cause. The bench creates this case by raising `wrEn` and `opValid` on the same falling edge. It then reads the flags back through register 26 and checks the trap. The gap handling in the condition-code window is checked with asymmetric bit patterns, read back through both register 25 and the full view, while FS sits next to the gap.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int WORD_W   = 32;
  localparam int REGNUM_W = 5;

  // field positions in the control word
  localparam int RM_LO    = 0;
  localparam int RM_W     = 2;
  localparam int FLAG_LO  = 2;
  localparam int FLAG_W   = 5;
  localparam int ENA_LO   = 7;
  localparam int CAUSE_LO = 12;
  localparam int CAUSE_W  = 6;
  localparam int CC0_BIT  = 23;
  localparam int FS_BIT   = 24;
  localparam int CCHI_LO  = 25;
  localparam int CCHI_W   = 7;
  localparam int CC_W     = CCHI_W + 1;

  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h007C_0000;

  // cause bit order
  localparam int C_INEX  = 0;
  localparam int C_UNDER = 1;
  localparam int C_OVER  = 2;
  localparam int C_DIVZ  = 3;
  localparam int C_INV   = 4;
  localparam int C_UNIMP = 5;

  // register numbers
  localparam logic [REGNUM_W-1:0] REG_IMPL = 5'd0;
  localparam logic [REGNUM_W-1:0] REG_CC   = 5'd25;
  localparam logic [REGNUM_W-1:0] REG_EXC  = 5'd26;
  localparam logic [REGNUM_W-1:0] REG_ENA  = 5'd28;
  localparam logic [REGNUM_W-1:0] REG_FULL = 5'd31;

  typedef struct packed {
    logic selImpl;
    logic selCc;
    logic selExc;
    logic selEna;
    logic selFull;
    logic wrCc;
    logic wrExc;
    logic wrEna;
    logic wrFull;
    logic opUpd;
  } strobe_t;
endpackage

// File: rtl/fcsr_ctrl.sv
module fcsr_ctrl
  import fcsr_pkg::*;
(
  input  logic [REGNUM_W-1:0] regNum,
  input  logic                wrEn,
  input  logic                opValid,
  output strobe_t             strobes
);
  always_comb begin
    strobes         = '0;
    strobes.selImpl = (regNum == REG_IMPL);
    strobes.selCc   = (regNum == REG_CC);
    strobes.selExc  = (regNum == REG_EXC);
    strobes.selEna  = (regNum == REG_ENA);
    strobes.selFull = (regNum == REG_FULL);
    strobes.wrCc    = wrEn && strobes.selCc;
    strobes.wrExc   = wrEn && strobes.selExc;
    strobes.wrEna   = wrEn && strobes.selEna;
    strobes.wrFull  = wrEn && strobes.selFull;
    strobes.opUpd   = opValid;
  end
endmodule

// File: rtl/fcsr_cause_map.sv
module fcsr_cause_map
  import fcsr_pkg::*;
#(
  parameter int INV_KINDS = 8,
  localparam int STATUS_W = INV_KINDS + 5
) (
  input  logic [STATUS_W-1:0] opStatus,
  output logic [CAUSE_W-1:0]  newCause
);
  localparam int DIVZ_IDX  = INV_KINDS;
  localparam int OVER_IDX  = INV_KINDS + 1;
  localparam int UNDER_IDX = INV_KINDS + 2;
  localparam int INEX_IDX  = INV_KINDS + 3;
  localparam int UNIMP_IDX = INV_KINDS + 4;

  always_comb begin
    newCause          = '0;
    newCause[C_INV]   = |opStatus[INV_KINDS-1:0];
    newCause[C_DIVZ]  = opStatus[DIVZ_IDX];
    newCause[C_OVER]  = opStatus[OVER_IDX];
    newCause[C_UNDER] = opStatus[UNDER_IDX];
    newCause[C_INEX]  = opStatus[INEX_IDX];
    newCause[C_UNIMP] = opStatus[UNIMP_IDX];
  end
endmodule

// File: rtl/fcsr_dp.sv
module fcsr_dp
  import fcsr_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL_ID = 32'h8A31_0042
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [CAUSE_W-1:0] newCause,
  output logic [WORD_W-1:0]  rdWord,
  output logic               trapReq
);
  logic [WORD_W-1:0] ctlWord;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] updated;
  logic              trapNext;

  // software write merge
  always_comb begin
    merged = ctlWord;
    if (strobes.wrFull) merged = wrData & ~RSVD_MASK;
    if (strobes.wrCc) begin
      merged[CC0_BIT]                 = wrData[0];
      merged[CCHI_LO +: CCHI_W]       = wrData[CC_W-1:1];
    end
    if (strobes.wrExc) begin
      merged[CAUSE_LO +: CAUSE_W]     = wrData[CAUSE_LO +: CAUSE_W];
      merged[FLAG_LO +: FLAG_W]       = wrData[FLAG_LO +: FLAG_W];
    end
    if (strobes.wrEna) begin
      merged[FS_BIT]                  = wrData[FLAG_LO];
      merged[ENA_LO +: FLAG_W]        = wrData[ENA_LO +: FLAG_W];
      merged[RM_LO +: RM_W]           = wrData[RM_LO +: RM_W];
    end
  end

  // operation update on top of the merged word
  always_comb begin
    updated  = merged;
    trapNext = 1'b0;
    if (strobes.opUpd) begin
      updated[CAUSE_LO +: CAUSE_W] = newCause;
      updated[FLAG_LO +: FLAG_W]   = merged[FLAG_LO +: FLAG_W] | newCause[FLAG_W-1:0];
      trapNext = (|(newCause[FLAG_W-1:0] & merged[ENA_LO +: FLAG_W])) || newCause[C_UNIMP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlWord <= '0;
      trapReq <= 1'b0;
    end else begin
      ctlWord <= updated;
      trapReq <= trapNext;
    end
  end

  // read views
  always_comb begin
    rdWord = '0;
    if (strobes.selImpl) rdWord = IMPL_ID;
    if (strobes.selFull) rdWord = ctlWord & ~RSVD_MASK;
    if (strobes.selCc) begin
      rdWord[0]        = ctlWord[CC0_BIT];
      rdWord[CC_W-1:1] = ctlWord[CCHI_LO +: CCHI_W];
    end
    if (strobes.selExc) begin
      rdWord[CAUSE_LO +: CAUSE_W] = ctlWord[CAUSE_LO +: CAUSE_W];
      rdWord[FLAG_LO +: FLAG_W]   = ctlWord[FLAG_LO +: FLAG_W];
    end
    if (strobes.selEna) begin
      rdWord[ENA_LO +: FLAG_W] = ctlWord[ENA_LO +: FLAG_W];
      rdWord[RM_LO +: RM_W]    = ctlWord[RM_LO +: RM_W];
      rdWord[FLAG_LO]          = ctlWord[FS_BIT];
    end
  end
endmodule

// File: rtl/fcsr_file.sv
module fcsr_file
  import fcsr_pkg::*;
#(
  parameter logic [31:0] IMPL_ID  = 32'h8A31_0042,
  parameter int INV_KINDS = 8,
  parameter int OUT_W     = 64,
  localparam int STATUS_W = INV_KINDS + 5,
  localparam int EXT_W    = OUT_W - WORD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          regNum,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  output logic [OUT_W-1:0]    rdData,
  input  logic                opValid,
  input  logic [STATUS_W-1:0] opStatus,
  output logic                trapReq
);
  strobe_t            strobes;
  logic [CAUSE_W-1:0] newCause;
  logic [WORD_W-1:0]  rdWord;

  fcsr_ctrl u_ctrl (
    .regNum (regNum),
    .wrEn   (wrEn),
    .opValid(opValid),
    .strobes(strobes)
  );

  fcsr_cause_map #(.INV_KINDS(INV_KINDS)) u_cause (
    .opStatus(opStatus),
    .newCause(newCause)
  );

  fcsr_dp #(.IMPL_ID(IMPL_ID)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .newCause(newCause),
    .rdWord  (rdWord),
    .trapReq (trapReq)
  );

  assign rdData = {{EXT_W{rdWord[WORD_W-1]}}, rdWord};
endmodule

// File: rtl/fcsr_checks.sv
module fcsr_checks #(
  parameter logic [31:0] IMPL_ID  = 32'h8A31_0042,
  parameter int INV_KINDS = 8,
  parameter int OUT_W     = 64,
  localparam int STATUS_W = INV_KINDS + 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [4:0]          regNum,
  input logic                wrEn,
  input logic [OUT_W-1:0]    rdData,
  input logic                opValid,
  input logic [STATUS_W-1:0] opStatus,
  input logic                trapReq
);
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rstN)
    rdData[OUT_W-1:32] == {(OUT_W-32){rdData[31]}}); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regNum == 5'd31) |-> (rdData[22:18] == 5'd0)); // R2

  AST_IMPL_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (regNum == 5'd0) |-> (rdData[31:0] == IMPL_ID)); // R7

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regNum != 5'd0 && regNum != 5'd25 && regNum != 5'd26 &&
     regNum != 5'd28 && regNum != 5'd31) |-> (rdData == '0)); // R7

  AST_UNIMP_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opStatus[STATUS_W-1]) |=> trapReq); // R11

  AST_NO_OP_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opStatus == '0) |=> !trapReq); // R11

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (regNum == 5'd26 && $past(regNum) == 5'd26 && !$past(wrEn)) |->
    ((rdData[6:2] & $past(rdData[6:2])) == $past(rdData[6:2]))); // R10
endmodule

bind fcsr_file fcsr_checks #(
  .IMPL_ID(IMPL_ID), .INV_KINDS(INV_KINDS), .OUT_W(OUT_W)
) u_checks (
  .clk(clk), .rstN(rstN), .regNum(regNum), .wrEn(wrEn), .rdData(rdData),
  .opValid(opValid), .opStatus(opStatus), .trapReq(trapReq)
);

// File: tb/fcsr_file_bench.sv
`timescale 1ns/1ps
module fcsr_file_bench;
  localparam logic [31:0] IMPL = 32'h8A31_0042;
  localparam int INVK = 8;
  localparam int SW = INVK + 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    regNum = '0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [63:0]   rdData;
  logic          opValid = 1'b0;
  logic [SW-1:0] opStatus = '0;
  logic          trapReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  fcsr_file #(.IMPL_ID(IMPL), .INV_KINDS(INVK), .OUT_W(64)) u_fcsr_file (
    .clk(clk), .rstN(rstN), .regNum(regNum), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .opValid(opValid), .opStatus(opStatus), .trapReq(trapReq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] r, input logic [31:0] v);
    @(negedge clk);
    regNum = r; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] r, input logic [31:0] e, input string req);
    @(negedge clk);
    regNum = r;
    #1 chk(req, rdData, {{32{e[31]}}, e});
  endtask

  task automatic op(input logic [SW-1:0] s, input logic expTrap, input string req);
    @(negedge clk);
    opValid = 1'b1; opStatus = s;
    @(negedge clk);
    opValid = 1'b0; opStatus = '0;
    chk(req, {63'd0, trapReq}, {63'd0, expTrap});
  endtask

  task automatic tReset;
    chk("R1 trap", {63'd0, trapReq}, 64'd0);
    rd(5'd31, 32'h0, "R1 full");
    rd(5'd25, 32'h0, "R1 cc");
    rd(5'd26, 32'h0, "R1 exc");
    rd(5'd28, 32'h0, "R1 ena");
    rd(5'd0, IMPL, "R7/R8 impl sign-extended");
  endtask

  task automatic tFull;
    wr(5'd31, 32'hFFFF_FFFF);
    rd(5'd31, 32'hFF83_FFFF, "R2 reserved bits zero, R8");
  endtask

  task automatic tCc;
    wr(5'd31, 32'h0);
    wr(5'd25, 32'h0000_00A5);
    rd(5'd31, 32'hA480_0000, "R4 gap reinserted");
    rd(5'd25, 32'h0000_00A5, "R3 gap removed");
    wr(5'd31, 32'h0100_0003);
    wr(5'd25, 32'hFFFF_FFFF);
    rd(5'd31, 32'hFF80_0003, "R4 FS kept set");
    rd(5'd25, 32'h0000_00FF, "R3 upper zero");
    wr(5'd25, 32'h0);
    rd(5'd31, 32'h0100_0003, "R4 only cc cleared");
  endtask

  task automatic tExc;
    wr(5'd31, 32'hFFFF_FFFF);
    wr(5'd26, 32'h0);
    rd(5'd31, 32'hFF80_0F83, "R5 others preserved");
    rd(5'd26, 32'h0, "R5 cleared");
    wr(5'd26, 32'hFFFF_FFFF);
    rd(5'd26, 32'h0003_F07C, "R5 view mask");
  endtask

  task automatic tEna;
    wr(5'd31, 32'h0);
    wr(5'd28, 32'hFFFF_FFFF);
    rd(5'd31, 32'h0100_0F83, "R6 write fields");
    rd(5'd28, 32'h0000_0F87, "R6 read with FS at bit 2");
    wr(5'd31, 32'h0083_F07C);
    wr(5'd28, 32'h0000_0004);
    rd(5'd31, 32'h0183_F07C, "R6 keeps cc/cause/flags");
    rd(5'd28, 32'h0000_0004, "R6 FS only");
    wr(5'd28, 32'h0000_0081);
    rd(5'd31, 32'h0083_F0FD, "R6 FS cleared");
  endtask

  task automatic tHoles;
    wr(5'd31, 32'h0);
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, 32'h0, "R7 hole reads zero");
    rd(5'd31, 32'h0, "R7 hole write ignored");
    wr(5'd0, 32'h0);
    rd(5'd0, IMPL, "R7 impl read-only");
  endtask

  task automatic tOps;
    wr(5'd31, 32'h0);
    op(13'h0008, 1'b0, "R11 no enable no trap");
    rd(5'd26, 32'h0001_0040, "R9 invalid kind sets V, R10");
    op(13'h0A00, 1'b0, "R11 inexact+overflow");
    rd(5'd26, 32'h0000_5054, "R9 cause replaced, R10 flags accumulate");
    op(13'h0000, 1'b0, "R11 clean op");
    rd(5'd26, 32'h0000_0054, "R9 cause cleared, R10 flags kept");
    op(13'h1000, 1'b1, "R11 unimplemented traps regardless");
    @(negedge clk);
    chk("R11 single pulse", {63'd0, trapReq}, 64'd0);
    rd(5'd26, 32'h0002_0054, "R10 E not in flags");
  endtask

  task automatic tEnabled;
    wr(5'd31, 32'h0000_0100);
    op(13'h0400, 1'b1, "R11 enabled underflow traps");
    rd(5'd26, 32'h0000_2008, "R9 underflow cause");
    op(13'h0100, 1'b0, "R11 divz not enabled");
  endtask

  task automatic tConcurrent;
    wr(5'd31, 32'h0);
    @(negedge clk);
    regNum = 5'd26; wrData = 32'h0000_0004; wrEn = 1'b1;
    opValid = 1'b1; opStatus = 13'h0100;
    @(negedge clk);
    wrEn = 1'b0; opValid = 1'b0; opStatus = '0;
    rd(5'd26, 32'h0000_8024, "R12 write then update");
    @(negedge clk);
    regNum = 5'd28; wrData = 32'h0000_0400; wrEn = 1'b1;
    opValid = 1'b1; opStatus = 13'h0100;
    @(negedge clk);
    wrEn = 1'b0; opValid = 1'b0; opStatus = '0;
    chk("R12 trap uses written enables", {63'd0, trapReq}, 64'd1);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFull();
    tCc();
    tExc();
    tEna();
    tHoles();
    tOps();
    tEnabled();
    tConcurrent();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule